// File: doc/BRIEF.md
# VLAN Membership Table Command Engine

The block keeps a VLAN membership table with one entry per VLAN ID in on-chip memory. Software never addresses the table directly. It loads two data words, then writes a command word that names a VLAN ID and an operation with its start flag set. The engine copies the entry into or out of the data words and drops the start flag when the copy is complete. Software polls that flag. A read-only lookup port serves the ingress pipeline. Given a VLAN ID, it returns the entry's valid flag, member mask and per-port egress tag codes one cycle later.

Each entry holds a valid flag, an independent-learning select, a per-VLAN egress tag enable, a member mask with one bit per port, and a 2-bit egress tag code per port. A VLAN is removed by writing all-zero data words into its entry. After reset, the engine sweeps the whole table to zero before it accepts any command.

Top module: `vlan_cmd_engine`

## Requirements
- R1: After reset the engine holds the start flag (command bit 31) set while a sweep writes every entry to zero. Afterwards every command read returns zero data words and every lookup misses.
- R2: The register select `reg_addr` is 0 for the command word, 1 for data word 1 and 2 for data word 2. In the command word, bit 31 is the start/busy flag, bit 16 is the invalid flag, bits 15:12 are the operation code and bits 11:0 are the VLAN ID (only the low VID_W bits are significant). A command-word write with bit 31 clear changes nothing.
- R3: Operation code 0 copies the addressed entry into both data words. Operation code 1 stores both data words into the addressed entry.
- R4: In data word 1, bit 0 is valid, bits 23:16 are the member mask (bit 16+p for port p), bit 28 is the tag enable and bit 30 is the learning select. Every other bit reads back as zero.
- R5: Data word 2 holds the egress tag code of port p in bits 2p+1:2p. The bits above the last port read back as zero.
- R6: Storing all-zero data words removes a VLAN: later lookups miss and later reads return zero.
- R7: An operation code other than 0 or 1, or a VLAN ID of 0 or all ones, completes with the invalid flag set. The table and the data words are left unchanged. A good command clears the flag.
- R8: While busy is set, writes to the command word and to both data words are ignored.
- R9: With no lookup traffic, busy reads set for exactly three cycles after the cycle in which a good command is written. The memory access happens in the first of these cycles, and busy clears two cycles after it.
- R10: Asserting `lk_en` with a VLAN ID raises `lk_ack` in the next cycle, with `lk_hit`, `lk_members`, `lk_etag`, `lk_tag_en` and `lk_ivl` taken from that entry.
- R11: A lookup always wins the memory. Each cycle in which `lk_en` is high while a command waits for its access delays that command by one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 command, 1 data word 1, 2 data word 2 |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read-back of the selected register |
| lk_en | input | 1 | Ingress lookup request |
| lk_vid | input | VID_W | VLAN ID to look up |
| lk_ack | output | 1 | Lookup result valid |
| lk_hit | output | 1 | Looked-up entry is valid |
| lk_members | output | NPORT | Member mask of the entry |
| lk_etag | output | 2*NPORT | Egress tag code per port |
| lk_tag_en | output | 1 | Per-VLAN tag enable of the entry |
| lk_ivl | output | 1 | Learning select of the entry |

## Verification
An ingress lookup and a pending command access can want the single memory port in the same cycle. The bench issues a command and holds `lk_en` high for one, two and then three cycles, starting in the command's access slot. It expects busy to stay set for three cycles plus one per colliding cycle, and it expects each lookup to be acknowledged on the next cycle. Before and after each collision run, the table contents are confirmed by full sweeps of reads and lookups.

// File: rtl/vlan_tbl_pkg.sv
package vlan_tbl_pkg;

    // Command word layout
    localparam int CMD_BUSY_BIT = 31;
    localparam int CMD_INV_BIT  = 16;
    localparam int CMD_FN_LSB   = 12;
    localparam int CMD_VID_W    = 12;

    // Data word 1 layout
    localparam int D1_VALID_BIT = 0;
    localparam int D1_MEM_LSB   = 16;
    localparam int D1_VTAG_BIT  = 28;
    localparam int D1_IVL_BIT   = 30;

    // Operation codes
    localparam logic [3:0] FN_READ  = 4'd0;
    localparam logic [3:0] FN_WRITE = 4'd1;

    // Register selects
    localparam logic [1:0] SEL_CMD = 2'd0;
    localparam logic [1:0] SEL_D1  = 2'd1;
    localparam logic [1:0] SEL_D2  = 2'd2;

    typedef enum logic [2:0] {
        ST_CLR,
        ST_IDLE,
        ST_ACC,
        ST_WT1,
        ST_WT2
    } seq_st_e;

endpackage

// File: rtl/vlan_tbl_ram.sv
module vlan_tbl_ram #(
    parameter int AW = 12,
    parameter int DW = 27
) (
    input  logic          clk,
    input  logic          en,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] store [DEPTH];
    logic [DW-1:0] rdata_q;

    // Single port: one read or one write per cycle, registered read data.
    always_ff @(posedge clk) begin
        if (en) begin
            if (we) begin
                store[addr] <= wdata;
            end else begin
                rdata_q <= store[addr];
            end
        end
    end

    assign rdata = rdata_q;
endmodule

// File: rtl/vlan_port_arb.sv
module vlan_port_arb #(
    parameter int AW = 12,
    parameter int DW = 27
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          lk_en,
    input  logic [AW-1:0] lk_vid,
    input  logic          eng_req,
    input  logic          eng_we,
    input  logic [AW-1:0] eng_addr,
    input  logic [DW-1:0] eng_wdata,
    output logic          m_en,
    output logic          m_we,
    output logic [AW-1:0] m_addr,
    output logic [DW-1:0] m_wdata,
    output logic          eng_gnt,
    output logic          lk_ack
);
    logic ack_d, ack_q;

    // Lookup has fixed priority; the engine takes the port only when idle.
    always_comb begin
        eng_gnt = eng_req && !lk_en;
        m_en    = lk_en || eng_req;
        m_we    = eng_gnt && eng_we;
        m_addr  = lk_en ? lk_vid : eng_addr;
        m_wdata = eng_wdata;
        ack_d   = lk_en;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ack_q <= 1'b0;
        end else begin
            ack_q <= ack_d;
        end
    end

    assign lk_ack = ack_q;
endmodule

// File: rtl/vlan_cmd_seq.sv
module vlan_cmd_seq
    import vlan_tbl_pkg::*;
#(
    parameter int VID_W = 12,
    parameter int NPORT = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_wr,
    input  logic [1:0]           reg_addr,
    input  logic [31:0]          reg_wdata,
    input  logic                 eng_gnt,
    input  logic [3*NPORT+2:0]   mem_rdata,
    output logic                 eng_req,
    output logic                 eng_we,
    output logic [VID_W-1:0]     eng_addr,
    output logic [3*NPORT+2:0]   eng_wdata,
    output logic                 busy,
    output logic                 inv,
    output logic [3:0]           func,
    output logic [VID_W-1:0]     vid,
    output logic                 d_valid,
    output logic                 d_ivl,
    output logic                 d_vtag,
    output logic [NPORT-1:0]     d_members,
    output logic [2*NPORT-1:0]   d_etag,
    output logic                 clr_active
);
    localparam int EW       = 3 * NPORT + 3;
    localparam int OFS_MEM  = 1;
    localparam int OFS_VTAG = NPORT + 1;
    localparam int OFS_IVL  = NPORT + 2;
    localparam int OFS_ETAG = NPORT + 3;
    localparam logic [VID_W-1:0] VID_TOP = '1;

    typedef struct packed {
        seq_st_e              st;
        logic [VID_W-1:0]     idx;
        logic                 busy;
        logic                 inv;
        logic [3:0]           func;
        logic [VID_W-1:0]     vid;
        logic                 valid;
        logic                 ivl;
        logic                 vtag;
        logic [NPORT-1:0]     members;
        logic [2*NPORT-1:0]   etag;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [VID_W-1:0] new_vid;
    logic [3:0]       new_fn;
    logic             new_bad;
    logic             unused_bits;

    assign new_vid     = reg_wdata[VID_W-1:0];
    assign new_fn      = reg_wdata[CMD_FN_LSB +: 4];
    assign new_bad     = (new_fn != FN_READ && new_fn != FN_WRITE) ||
                         new_vid == '0 || new_vid == VID_TOP;
    assign unused_bits = ^{reg_wdata[29], reg_wdata[27:24]};

    always_comb begin
        ctl_d     = ctl_q;
        eng_req   = 1'b0;
        eng_we    = 1'b0;
        eng_addr  = ctl_q.vid;
        eng_wdata = {ctl_q.etag, ctl_q.ivl, ctl_q.vtag, ctl_q.members, ctl_q.valid};

        case (ctl_q.st)
            ST_CLR: begin
                eng_req   = 1'b1;
                eng_we    = 1'b1;
                eng_addr  = ctl_q.idx;
                eng_wdata = '0;
                if (eng_gnt) begin
                    if (ctl_q.idx == VID_TOP) begin
                        ctl_d.st   = ST_IDLE;
                        ctl_d.busy = 1'b0;
                    end else begin
                        ctl_d.idx = ctl_q.idx + 1'b1;
                    end
                end
            end
            ST_IDLE: begin
                if (reg_wr) begin
                    case (reg_addr)
                        SEL_CMD: begin
                            if (reg_wdata[CMD_BUSY_BIT]) begin
                                ctl_d.st   = ST_ACC;
                                ctl_d.busy = 1'b1;
                                ctl_d.func = new_fn;
                                ctl_d.vid  = new_vid;
                                ctl_d.inv  = new_bad;
                            end
                        end
                        SEL_D1: begin
                            ctl_d.valid   = reg_wdata[D1_VALID_BIT];
                            ctl_d.members = reg_wdata[D1_MEM_LSB +: NPORT];
                            ctl_d.vtag    = reg_wdata[D1_VTAG_BIT];
                            ctl_d.ivl     = reg_wdata[D1_IVL_BIT];
                        end
                        SEL_D2: begin
                            ctl_d.etag = reg_wdata[2*NPORT-1:0];
                        end
                        default: ;
                    endcase
                end
            end
            ST_ACC: begin
                if (ctl_q.inv) begin
                    ctl_d.st = ST_WT1;
                end else begin
                    eng_req = 1'b1;
                    eng_we  = (ctl_q.func == FN_WRITE);
                    if (eng_gnt) begin
                        ctl_d.st = ST_WT1;
                    end
                end
            end
            ST_WT1: begin
                if (!ctl_q.inv && ctl_q.func == FN_READ) begin
                    ctl_d.valid   = mem_rdata[0];
                    ctl_d.members = mem_rdata[OFS_MEM +: NPORT];
                    ctl_d.vtag    = mem_rdata[OFS_VTAG];
                    ctl_d.ivl     = mem_rdata[OFS_IVL];
                    ctl_d.etag    = mem_rdata[EW-1:OFS_ETAG];
                end
                ctl_d.st = ST_WT2;
            end
            ST_WT2: begin
                ctl_d.st   = ST_IDLE;
                ctl_d.busy = 1'b0;
            end
            default: begin
                ctl_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q      <= '0;
            ctl_q.st   <= ST_CLR;
            ctl_q.busy <= 1'b1;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign busy       = ctl_q.busy;
    assign inv        = ctl_q.inv;
    assign func       = ctl_q.func;
    assign vid        = ctl_q.vid;
    assign d_valid    = ctl_q.valid;
    assign d_ivl      = ctl_q.ivl;
    assign d_vtag     = ctl_q.vtag;
    assign d_members  = ctl_q.members;
    assign d_etag     = ctl_q.etag;
    assign clr_active = (ctl_q.st == ST_CLR);
endmodule

// File: rtl/vlan_cmd_engine.sv
module vlan_cmd_engine
    import vlan_tbl_pkg::*;
#(
    parameter int VID_W = 12,
    parameter int NPORT = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_wr,
    input  logic [1:0]           reg_addr,
    input  logic [31:0]          reg_wdata,
    output logic [31:0]          reg_rdata,
    input  logic                 lk_en,
    input  logic [VID_W-1:0]     lk_vid,
    output logic                 lk_ack,
    output logic                 lk_hit,
    output logic [NPORT-1:0]     lk_members,
    output logic [2*NPORT-1:0]   lk_etag,
    output logic                 lk_tag_en,
    output logic                 lk_ivl
);
    localparam int EW = 3 * NPORT + 3;

    logic                eng_req, eng_we, eng_gnt;
    logic [VID_W-1:0]    eng_addr;
    logic [EW-1:0]       eng_wdata;
    logic                mem_en, mem_we;
    logic [VID_W-1:0]    mem_addr;
    logic [EW-1:0]       mem_wdata, mem_rdata;
    logic                cmd_busy, cmd_inv, clr_active;
    logic [3:0]          cmd_func;
    logic [VID_W-1:0]    cmd_vid;
    logic                d_valid, d_ivl, d_vtag;
    logic [NPORT-1:0]    d_members;
    logic [2*NPORT-1:0]  d_etag;
    logic [31:0]         cmd_word, d1_word, d2_word;
    logic [CMD_VID_W-1:0] vid_ext;

    vlan_cmd_seq #(.VID_W(VID_W), .NPORT(NPORT)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_wr     (reg_wr),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .eng_gnt    (eng_gnt),
        .mem_rdata  (mem_rdata),
        .eng_req    (eng_req),
        .eng_we     (eng_we),
        .eng_addr   (eng_addr),
        .eng_wdata  (eng_wdata),
        .busy       (cmd_busy),
        .inv        (cmd_inv),
        .func       (cmd_func),
        .vid        (cmd_vid),
        .d_valid    (d_valid),
        .d_ivl      (d_ivl),
        .d_vtag     (d_vtag),
        .d_members  (d_members),
        .d_etag     (d_etag),
        .clr_active (clr_active)
    );

    vlan_port_arb #(.AW(VID_W), .DW(EW)) u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .lk_en     (lk_en),
        .lk_vid    (lk_vid),
        .eng_req   (eng_req),
        .eng_we    (eng_we),
        .eng_addr  (eng_addr),
        .eng_wdata (eng_wdata),
        .m_en      (mem_en),
        .m_we      (mem_we),
        .m_addr    (mem_addr),
        .m_wdata   (mem_wdata),
        .eng_gnt   (eng_gnt),
        .lk_ack    (lk_ack)
    );

    vlan_tbl_ram #(.AW(VID_W), .DW(EW)) u_ram (
        .clk   (clk),
        .en    (mem_en),
        .we    (mem_we),
        .addr  (mem_addr),
        .wdata (mem_wdata),
        .rdata (mem_rdata)
    );

    // Lookup result unpacking: {etag, ivl, vtag, members, valid}
    assign lk_hit     = mem_rdata[0];
    assign lk_members = mem_rdata[NPORT:1];
    assign lk_tag_en  = mem_rdata[NPORT+1];
    assign lk_ivl     = mem_rdata[NPORT+2];
    assign lk_etag    = mem_rdata[EW-1:NPORT+3];

    // Register images
    assign vid_ext  = CMD_VID_W'(cmd_vid);
    assign cmd_word = {cmd_busy, 14'd0, cmd_inv, cmd_func, vid_ext};

    always_comb begin
        d1_word                     = '0;
        d1_word[D1_VALID_BIT]       = d_valid;
        d1_word[D1_MEM_LSB +: NPORT] = d_members;
        d1_word[D1_VTAG_BIT]        = d_vtag;
        d1_word[D1_IVL_BIT]         = d_ivl;
    end

    for (genvar p = 0; p < NPORT; p++) begin : g_etag
        assign d2_word[2*p +: 2] = d_etag[2*p +: 2];
    end
    if (2 * NPORT < 32) begin : g_d2_pad
        assign d2_word[31:2*NPORT] = '0;
    end

    always_comb begin
        case (reg_addr)
            SEL_CMD: reg_rdata = cmd_word;
            SEL_D1:  reg_rdata = d1_word;
            SEL_D2:  reg_rdata = d2_word;
            default: reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/vlan_cmd_engine_chk.sv
module vlan_cmd_engine_chk #(
    parameter int VID_W = 12,
    parameter int NPORT = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 reg_wr,
    input logic [1:0]           reg_addr,
    input logic                 lk_en,
    input logic                 lk_ack,
    input logic                 eng_gnt,
    input logic                 mem_we,
    input logic [3*NPORT+2:0]   mem_wdata,
    input logic                 cmd_busy,
    input logic                 cmd_inv,
    input logic [3:0]           cmd_func,
    input logic [VID_W-1:0]     cmd_vid,
    input logic                 clr_active
);
    // R1: the sweep writes zeros only and keeps busy raised
    p_sweep_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_active && mem_we) |-> (mem_wdata == '0 && cmd_busy));

    // R7: a command write to memory only for a good store command
    p_no_bad_store_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && !clr_active) |-> (cmd_func == 4'd1 && !cmd_inv));

    // R8: command word writes during busy leave it unchanged
    p_busy_ignore_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_busy && reg_wr && reg_addr == 2'd0) |=> ($stable(cmd_vid) && $stable(cmd_func)));

    // R9: busy clears two cycles after the command's memory access
    p_busy_tail_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_gnt && !clr_active) |=> cmd_busy ##1 cmd_busy ##1 !cmd_busy);

    // R10: every lookup is acknowledged on the following cycle
    p_lookup_ack_r10: assert property (@(posedge clk) disable iff (!rst_n)
        lk_en |=> lk_ack);

    // R11: the engine never owns the memory while a lookup is requested
    p_lookup_first_r11: assert property (@(posedge clk) disable iff (!rst_n)
        lk_en |-> !eng_gnt);
endmodule

bind vlan_cmd_engine vlan_cmd_engine_chk #(.VID_W(VID_W), .NPORT(NPORT)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr),
    .lk_en      (lk_en),
    .lk_ack     (lk_ack),
    .eng_gnt    (eng_gnt),
    .mem_we     (mem_we),
    .mem_wdata  (mem_wdata),
    .cmd_busy   (cmd_busy),
    .cmd_inv    (cmd_inv),
    .cmd_func   (cmd_func),
    .cmd_vid    (cmd_vid),
    .clr_active (clr_active)
);

// File: tb/tb_vlan_cmd_engine.sv
module tb_vlan_cmd_engine;
    localparam int VID_W = 4;
    localparam int NPORT = 8;
    localparam int DEPTH = 1 << VID_W;
    localparam int TOPV  = DEPTH - 1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              reg_wr = 1'b0;
    logic [1:0]        reg_addr = 2'd0;
    logic [31:0]       reg_wdata = '0;
    logic [31:0]       reg_rdata;
    logic              lk_en = 1'b0;
    logic [VID_W-1:0]  lk_vid = '0;
    logic              lk_ack, lk_hit, lk_tag_en, lk_ivl;
    logic [NPORT-1:0]  lk_members;
    logic [2*NPORT-1:0] lk_etag;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    vlan_cmd_engine #(.VID_W(VID_W), .NPORT(NPORT)) dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .lk_en(lk_en),
        .lk_vid(lk_vid), .lk_ack(lk_ack), .lk_hit(lk_hit),
        .lk_members(lk_members), .lk_etag(lk_etag), .lk_tag_en(lk_tag_en),
        .lk_ivl(lk_ivl)
    );

    function automatic logic [7:0] pat_mem(input int v);
        return 8'((v * 37 + 5) & 8'hff);
    endfunction
    function automatic logic [15:0] pat_etag(input int v);
        return 16'((v * 16'h9e37) ^ 16'h1234);
    endfunction
    function automatic logic [31:0] pat_d1(input int v);
        logic [31:0] w;
        w = 32'(pat_mem(v)) << 16;
        w[30] = v[0];
        w[28] = v[1];
        w[0]  = 1'b1;
        return w;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_addr = 2'd0;
    endtask

    task automatic rd_reg(input logic [1:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
        reg_addr = 2'd0;
        #1;
    endtask

    // Issue a command, hold lk_en for k cycles from the access slot, count busy cycles.
    task automatic run_cmd(input logic [3:0] fn, input int v, input int k, output int cyc);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 2'd0;
        reg_wdata = {1'b1, 15'd0, fn, 12'(v)};
        @(negedge clk);
        reg_wr = 1'b0;
        cyc = 0;
        #1;
        while (reg_rdata[31] && cyc < 60) begin
            lk_en = (cyc < k);
            lk_vid = VID_W'(v);
            cyc++;
            @(negedge clk);
            #1;
        end
        lk_en = 1'b0;
    endtask

    task automatic look(input int v, output logic [31:0] res);
        @(negedge clk);
        lk_en = 1'b1; lk_vid = VID_W'(v);
        @(negedge clk);
        lk_en = 1'b0;
        res = {5'd0, lk_ack, lk_ivl, lk_tag_en, lk_members, lk_etag[15:0]} | 32'(lk_hit) << 31;
    endtask

    function automatic logic [31:0] exp_look(input bit hit, input int v);
        logic [31:0] r;
        r = {5'd0, 1'b1, 1'b0, 1'b0, 8'd0, 16'd0};
        if (hit) r = r | (32'(v[0]) << 25) | (32'(v[1]) << 24) |
                     (32'(pat_mem(v)) << 16) | 32'(pat_etag(v)) | 32'h8000_0000;
        return r;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] r, r2;
        int cyc;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: busy held during the clearing sweep
        @(negedge clk); #1;
        chk(reg_rdata[31] == 1'b1, "R1 busy after reset", reg_rdata, 32'h8000_0000);
        cyc = 0;
        while (reg_rdata[31] && cyc < 100) begin cyc++; @(negedge clk); #1; end
        chk(cyc >= DEPTH - 2 && cyc <= DEPTH + 1, "R1 sweep length", 32'(cyc), 32'(DEPTH - 1));

        // R1: every entry invalid after the sweep
        for (int v = 0; v < DEPTH; v++) begin
            look(v, r);
            chk(r == exp_look(0, v), "R1/R10 lookup after sweep", r, exp_look(0, v));
        end
        wr_reg(2'd1, 32'hFFFF_FFFF);
        wr_reg(2'd2, 32'hFFFF_FFFF);
        run_cmd(4'd0, 7, 0, cyc);
        rd_reg(2'd1, r); chk(r == 0, "R1 read d1 after sweep", r, 0);
        rd_reg(2'd2, r); chk(r == 0, "R1 read d2 after sweep", r, 0);

        // R8: writes while busy are ignored
        wr_reg(2'd1, pat_d1(4));
        wr_reg(2'd2, 32'(pat_etag(4)));
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = {1'b1, 15'd0, 4'd1, 12'd4};
        @(negedge clk);
        reg_addr = 2'd0; reg_wdata = {1'b1, 15'd0, 4'd1, 12'd6};
        @(negedge clk);
        reg_addr = 2'd1; reg_wdata = 32'h0;
        @(negedge clk);
        reg_wr = 1'b0; reg_addr = 2'd0;
        repeat (4) @(negedge clk);
        rd_reg(2'd0, r); chk(r[11:0] == 12'd4, "R8 cmd vid kept", r, 32'd4);
        rd_reg(2'd1, r); chk(r == pat_d1(4), "R8 d1 kept", r, pat_d1(4));
        look(6, r); chk(r == exp_look(0, 6), "R8 vid 6 untouched", r, exp_look(0, 6));
        look(4, r); chk(r == exp_look(1, 4), "R8 vid 4 stored", r, exp_look(1, 4));

        // R3/R4/R5/R9: store every legal VID with masked junk bits
        for (int v = 1; v < TOPV; v++) begin
            wr_reg(2'd1, pat_d1(v) | 32'h2C00_0006);
            rd_reg(2'd1, r); chk(r == pat_d1(v), "R4 d1 masking", r, pat_d1(v));
            wr_reg(2'd2, 32'(pat_etag(v)) | 32'hA5A5_0000);
            rd_reg(2'd2, r); chk(r == 32'(pat_etag(v)), "R5 d2 masking", r, 32'(pat_etag(v)));
            run_cmd(4'd1, v, 0, cyc);
            chk(cyc == 3, "R9 store latency", 32'(cyc), 32'd3);
        end
        for (int v = 1; v < TOPV; v++) begin
            wr_reg(2'd1, 0);
            wr_reg(2'd2, 0);
            run_cmd(4'd0, v, 0, cyc);
            chk(cyc == 3, "R9 read latency", 32'(cyc), 32'd3);
            rd_reg(2'd1, r); chk(r == pat_d1(v), "R3/R4 read back d1", r, pat_d1(v));
            rd_reg(2'd2, r); chk(r == 32'(pat_etag(v)), "R3/R5 read back d2", r, 32'(pat_etag(v)));
            rd_reg(2'd0, r); chk(r[16] == 1'b0, "R7 inv clear on good cmd", r, 0);
            look(v, r); chk(r == exp_look(1, v), "R10 lookup fields", r, exp_look(1, v));
        end

        // R2: command write without start bit does nothing
        rd_reg(2'd0, r2);
        wr_reg(2'd0, {1'b0, 15'd0, 4'd1, 12'd9});
        #1;
        rd_reg(2'd0, r); chk(r == r2, "R2 no start bit", r, r2);

        // R7: bad codes and reserved VIDs
        wr_reg(2'd1, 32'h0);
        wr_reg(2'd2, 32'h0);
        run_cmd(4'd2, 5, 0, cyc);
        rd_reg(2'd0, r); chk(r[16] == 1'b1 && r[31] == 1'b0, "R7 bad code inv", r, 32'h0001_2005);
        run_cmd(4'd1, 0, 0, cyc);
        rd_reg(2'd0, r); chk(r[16] == 1'b1, "R7 vid 0 inv", r, 32'h0001_1000);
        run_cmd(4'd1, TOPV, 0, cyc);
        rd_reg(2'd0, r); chk(r[16] == 1'b1, "R7 top vid inv", r, 32'h0001_100F);
        look(5, r); chk(r == exp_look(1, 5), "R7 table unchanged", r, exp_look(1, 5));
        look(0, r); chk(r == exp_look(0, 0), "R7 vid 0 unwritten", r, exp_look(0, 0));
        wr_reg(2'd1, 32'h1234_5671 & 32'h50FF_0001);
        run_cmd(4'd0, TOPV, 0, cyc);
        rd_reg(2'd1, r); chk(r == (32'h1234_5671 & 32'h50FF_0001), "R7 data kept on bad read", r, 32'h1034_0001);

        // R11: lookup collisions stretch the command
        for (int k = 1; k <= 3; k++) begin
            run_cmd(4'd0, 2 + k, k, cyc);
            chk(cyc == 3 + k, "R11 collision delay", 32'(cyc), 32'(3 + k));
            rd_reg(2'd1, r); chk(r == pat_d1(2 + k), "R11 read data after collision", r, pat_d1(2 + k));
        end

        // R6: all-zero store removes a VLAN
        wr_reg(2'd1, 0);
        wr_reg(2'd2, 0);
        run_cmd(4'd1, 3, 0, cyc);
        look(3, r); chk(r == exp_look(0, 3), "R6 removed lookup", r, exp_look(0, 3));
        wr_reg(2'd1, 32'hFFFF_FFFF);
        run_cmd(4'd0, 3, 0, cyc);
        rd_reg(2'd1, r); chk(r == 0, "R6 removed read", r, 0);
        look(2, r); chk(r == exp_look(1, 2), "R6 neighbour intact", r, exp_look(1, 2));

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule